// File: doc/BRIEF.md
# Debounced Window Extreme Latch

This block watches three quantized telemetry streams from a power rail: voltage, current and temperature. It keeps four running extremes: the lowest voltage, the highest voltage, the highest current and the highest temperature. Only values that have stayed in place long enough are counted. A new value becomes eligible to replace an extreme only after it has held for a programmable number of switching-period ticks. A blanking timer, started by a control-mode change pulse, holds off every update while ringing from the transition dies down.

The host reads the latch with a single strobe. On that strobe the four extremes and their valid bits are copied into registered snapshot outputs in one clock edge, and the live window is cleared in the same edge. The snapshot therefore covers exactly the samples that qualified since the previous read. A sample that qualifies in the cycle of the read goes into the new window and is not lost.

Top module: `peak_window_latch`

## Requirements
- R1: After reset the snapshot reads minimum all-ones, the three maxima zero, `snap_valid` zero and `snap_ready` low.
- R2: The voltage minimum extreme is replaced only by a qualified voltage value strictly below it, or by any qualified value when it holds no valid value.
- R3: Each maximum extreme (voltage, current, temperature) is replaced only by a qualified value of its own channel strictly above it, or by any qualified value when it holds no valid value.
- R4: A held value qualifies on the sw_tick at which it has beaten its extreme for `dbn_len` consecutive ticks. A `dbn_len` of 0 acts as 1. The count restarts when a strobe brings a different value, when a tick finds the value not beating the extreme, or when a read clears the window.
- R5: A `mode_chg` pulse loads a blanking count of `blank_len` ticks. While that count is non-zero, and in the pulse cycle itself, no extreme changes, and each tick seen restarts the debounce count.
- R6: A read strobe copies all four extremes and their valid bits to the snapshot outputs at the next clock edge and clears the window in the same edge. `snap_ready` is high for exactly the one cycle after the strobe, and the snapshot holds until the next read.
- R7: A value that qualifies in the same cycle as a read is stored in the new window. The snapshot taken in that cycle shows the window before it.
- R8: `snap_valid` bit 0 is the voltage minimum, bit 1 the voltage maximum, bit 2 the current maximum and bit 3 the temperature maximum. A bit is 1 only if its extreme took a qualified value during the window.
- R9: The first qualified value of a window is captured whatever its magnitude, including all-ones for the minimum and zero for a maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v_smp | input | SAMPLE_W | Voltage sample |
| v_stb | input | 1 | Voltage sample strobe |
| i_smp | input | SAMPLE_W | Current sample |
| i_stb | input | 1 | Current sample strobe |
| t_smp | input | SAMPLE_W | Temperature sample |
| t_stb | input | 1 | Temperature sample strobe |
| sw_tick | input | 1 | One pulse per switching period |
| mode_chg | input | 1 | Control-mode change pulse, starts blanking |
| blank_len | input | BLANK_W | Blanking length in switching ticks |
| dbn_len | input | DBN_W | Debounce length in switching ticks (0 acts as 1) |
| rd_stb | input | 1 | Host read strobe: snapshot and clear |
| snap_v_min | output | SAMPLE_W | Snapshot voltage minimum |
| snap_v_max | output | SAMPLE_W | Snapshot voltage maximum |
| snap_i_max | output | SAMPLE_W | Snapshot current maximum |
| snap_t_max | output | SAMPLE_W | Snapshot temperature maximum |
| snap_valid | output | 4 | Snapshot valid bits per extreme |
| snap_ready | output | 1 | High the cycle after a read |

## Verification
A strobe moves a value into the held register at the next edge. A tick that completes the debounce count writes the extreme at that same edge. A read copies the extremes into the snapshot outputs at the edge after the strobe, so a result is visible one cycle after the read strobe. The bench drives every input on the falling edge and samples the snapshot and `snap_ready` on the falling edge after the read edge. A check never looks at the extremes before a read has exposed them. Tick counts are issued one cycle at a time, so a debounce or blanking count is resolved by the time the read is driven.

// File: rtl/peak_window_pkg.sv
package peak_window_pkg;
  localparam int NUM_EXT = 4;
  localparam int EXT_VMIN = 0;
  localparam int EXT_VMAX = 1;
  localparam int EXT_IMAX = 2;
  localparam int EXT_TMAX = 3;

  typedef enum logic [1:0] {
    CH_VOLT = 2'd0,
    CH_CURR = 2'd1,
    CH_TEMP = 2'd2
  } chan_e;

  function automatic chan_e ext_chan(input int idx);
    case (idx)
      EXT_IMAX: return CH_CURR;
      EXT_TMAX: return CH_TEMP;
      default:  return CH_VOLT;
    endcase
  endfunction

  function automatic bit ext_is_min(input int idx);
    return idx == EXT_VMIN;
  endfunction
endpackage

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BLANK_W-1:0] len,
  input  logic               tick,
  output logic               active
);
  logic [BLANK_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= len;
    end else if (tick && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = start || (left_q != '0);
endmodule

// File: rtl/extreme_tracker.sv
module extreme_tracker #(
  parameter int SAMPLE_W = 12,
  parameter int DBN_W    = 2,
  parameter bit IS_MIN   = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                smp_stb,
  input  logic                tick,
  input  logic                blank,
  input  logic                clr,
  input  logic [DBN_W:0]      need,
  output logic [SAMPLE_W-1:0] ext,
  output logic                ext_ok
);
  localparam logic [SAMPLE_W-1:0] INIT = IS_MIN ? {SAMPLE_W{1'b1}} : {SAMPLE_W{1'b0}};

  logic [SAMPLE_W-1:0] held_q;
  logic                held_ok_q;
  logic [DBN_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] ext_q;
  logic                ok_q;
  logic                better;
  logic                beats;
  logic                changed;
  logic                commit;
  logic [DBN_W:0]      cnt_next;

  generate
    if (IS_MIN) begin : g_lt
      assign better = held_q < ext_q;
    end else begin : g_gt
      assign better = held_q > ext_q;
    end
  endgenerate

  assign beats    = held_ok_q && (!ok_q || better);
  assign changed  = smp_stb && (!held_ok_q || smp != held_q);
  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign commit   = tick && beats && !blank && (cnt_next >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q    <= '0;
      held_ok_q <= 1'b0;
      cnt_q     <= '0;
      ext_q     <= INIT;
      ok_q      <= 1'b0;
    end else begin
      if (smp_stb) begin
        held_q    <= smp;
        held_ok_q <= 1'b1;
      end
      if (changed || clr || commit || (tick && (!beats || blank))) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_next[DBN_W-1:0];
      end
      if (commit) begin
        ext_q <= held_q;
        ok_q  <= 1'b1;
      end else if (clr) begin
        ext_q <= INIT;
        ok_q  <= 1'b0;
      end
    end
  end

  assign ext    = ext_q;
  assign ext_ok = ok_q;
endmodule

// File: rtl/peak_window_latch.sv
module peak_window_latch
  import peak_window_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int BLANK_W  = 8,
  parameter int DBN_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] v_smp,
  input  logic                v_stb,
  input  logic [SAMPLE_W-1:0] i_smp,
  input  logic                i_stb,
  input  logic [SAMPLE_W-1:0] t_smp,
  input  logic                t_stb,
  input  logic                sw_tick,
  input  logic                mode_chg,
  input  logic [BLANK_W-1:0]  blank_len,
  input  logic [DBN_W-1:0]    dbn_len,
  input  logic                rd_stb,
  output logic [SAMPLE_W-1:0] snap_v_min,
  output logic [SAMPLE_W-1:0] snap_v_max,
  output logic [SAMPLE_W-1:0] snap_i_max,
  output logic [SAMPLE_W-1:0] snap_t_max,
  output logic [NUM_EXT-1:0]  snap_valid,
  output logic                snap_ready
);
  logic                              blank_on;
  logic [DBN_W:0]                    need;
  logic [NUM_EXT-1:0][SAMPLE_W-1:0]  ext_val;
  logic [NUM_EXT-1:0]                ext_ok;
  logic [2:0][SAMPLE_W-1:0]          ch_smp;
  logic [2:0]                        ch_stb;

  assign need = (dbn_len == '0) ? {{DBN_W{1'b0}}, 1'b1} : {1'b0, dbn_len};

  assign ch_smp[CH_VOLT] = v_smp;
  assign ch_smp[CH_CURR] = i_smp;
  assign ch_smp[CH_TEMP] = t_smp;
  assign ch_stb[CH_VOLT] = v_stb;
  assign ch_stb[CH_CURR] = i_stb;
  assign ch_stb[CH_TEMP] = t_stb;

  blank_timer #(.BLANK_W(BLANK_W)) u_blank (
    .clk   (clk),
    .rst   (rst),
    .start (mode_chg),
    .len   (blank_len),
    .tick  (sw_tick),
    .active(blank_on)
  );

  generate
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
      localparam chan_e CH = ext_chan(g);
      extreme_tracker #(
        .SAMPLE_W(SAMPLE_W),
        .DBN_W   (DBN_W),
        .IS_MIN  (ext_is_min(g))
      ) u_trk (
        .clk    (clk),
        .rst    (rst),
        .smp    (ch_smp[CH]),
        .smp_stb(ch_stb[CH]),
        .tick   (sw_tick),
        .blank  (blank_on),
        .clr    (rd_stb),
        .need   (need),
        .ext    (ext_val[g]),
        .ext_ok (ext_ok[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_v_min <= '1;
      snap_v_max <= '0;
      snap_i_max <= '0;
      snap_t_max <= '0;
      snap_valid <= '0;
      snap_ready <= 1'b0;
    end else begin
      snap_ready <= rd_stb;
      if (rd_stb) begin
        snap_v_min <= ext_val[EXT_VMIN];
        snap_v_max <= ext_val[EXT_VMAX];
        snap_i_max <= ext_val[EXT_IMAX];
        snap_t_max <= ext_val[EXT_TMAX];
        snap_valid <= ext_ok;
      end
    end
  end
endmodule

// File: rtl/peak_window_chk.sv
module peak_window_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rd_stb,
  input logic                    sw_tick,
  input logic                    blank_on,
  input logic                    snap_ready,
  input logic [SAMPLE_W-1:0]     snap_v_min,
  input logic [3:0]              snap_valid,
  input logic [3:0][SAMPLE_W-1:0] ext_val
);
  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> snap_ready);
  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !snap_ready);
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ($stable(snap_v_min) && $stable(snap_valid)));
  assert_blank_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (blank_on && !rd_stb) |=> $stable(ext_val));
  assert_tick_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!sw_tick && !rd_stb) |=> $stable(ext_val));
  assert_vmin_down_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ext_val[0] <= $past(ext_val[0]));
  assert_vmax_up_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ext_val[1] >= $past(ext_val[1]));
  assert_imax_up_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ext_val[2] >= $past(ext_val[2]));
endmodule

bind peak_window_latch peak_window_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/peak_window_latch_bench.sv
module peak_window_latch_bench;
  localparam int W = 12;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  typedef struct packed {
    logic [W-1:0] v0, i0, t0;
    logic [3:0]   n0;
    logic [W-1:0] v1, i1, t1;
    logic [3:0]   n1;
    logic [W-1:0] evmin, evmax, eimax, etmax;
    logic [3:0]   evalid;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{12'd100, 12'd50, 12'd30, 4'd2, 12'd180, 12'd40, 12'd35, 4'd2,
      12'd100, 12'd180, 12'd50, 12'd35, 4'hF},
    '{12'd500, 12'd10, 12'd20, 4'd1, 12'd400, 12'd20, 12'd10, 4'd1,
      12'hFFF, 12'd0, 12'd0, 12'd0, 4'h0},
    '{12'd400, 12'd20, 12'd10, 4'd1, 12'd400, 12'd20, 12'd10, 4'd1,
      12'd400, 12'd400, 12'd20, 12'd10, 4'hF},
    '{12'hFFF, 12'hFFF, 12'hFFF, 4'd2, 12'd0, 12'd0, 12'd0, 4'd2,
      12'd0, 12'hFFF, 12'hFFF, 12'hFFF, 4'hF},
    '{12'd0, 12'd0, 12'd0, 4'd2, 12'd0, 12'd0, 12'd0, 4'd0,
      12'd0, 12'd0, 12'd0, 12'd0, 4'hF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] v_smp = '0, i_smp = '0, t_smp = '0;
  logic v_stb = 0, i_stb = 0, t_stb = 0, sw_tick = 0, mode_chg = 0, rd_stb = 0;
  logic [7:0] blank_len = '0;
  logic [1:0] dbn_len = 2'd2;
  logic [W-1:0] snap_v_min, snap_v_max, snap_i_max, snap_t_max;
  logic [3:0] snap_valid;
  logic snap_ready;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  peak_window_latch u_peak_window_latch (
    .clk, .rst, .v_smp, .v_stb, .i_smp, .i_stb, .t_smp, .t_stb,
    .sw_tick, .mode_chg, .blank_len, .dbn_len, .rd_stb,
    .snap_v_min, .snap_v_max, .snap_i_max, .snap_t_max, .snap_valid, .snap_ready
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [W-1:0] v, input logic [W-1:0] i, input logic [W-1:0] t);
    v_smp = v; i_smp = i; t_smp = t;
    v_stb = 1; i_stb = 1; t_stb = 1;
    @(negedge clk);
    v_stb = 0; i_stb = 0; t_stb = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      sw_tick = 1;
      @(negedge clk);
      sw_tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input string tag, input bit with_tick,
                          input logic [W-1:0] emin, input logic [W-1:0] emax,
                          input logic [W-1:0] ei, input logic [W-1:0] et,
                          input logic [3:0] ev);
    rd_stb = 1;
    sw_tick = with_tick;
    @(negedge clk);
    rd_stb = 0;
    sw_tick = 0;
    check({tag, " R6 ready"}, snap_ready, 1);
    check({tag, " R2 vmin"}, snap_v_min, emin);
    check({tag, " R3 vmax"}, snap_v_max, emax);
    check({tag, " R3 imax"}, snap_i_max, ei);
    check({tag, " R3 tmax"}, snap_t_max, et);
    check({tag, " R8 valid"}, snap_valid, ev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state of the snapshot
    check("R1 vmin", snap_v_min, ONES);
    check("R1 vmax", snap_v_max, 0);
    check("R1 valid", snap_valid, 0);
    check("R1 ready", snap_ready, 0);

    // Vector table, debounce of 2 ticks (R2 R3 R4 R8 R9)
    dbn_len = 2'd2;
    for (int n = 0; n < NV; n++) begin
      strobe(VECS[n].v0, VECS[n].i0, VECS[n].t0);
      ticks(int'(VECS[n].n0));
      strobe(VECS[n].v1, VECS[n].i1, VECS[n].t1);
      ticks(int'(VECS[n].n1));
      read_chk($sformatf("vec%0d R4 R9", n), 0, VECS[n].evmin, VECS[n].evmax,
               VECS[n].eimax, VECS[n].etmax, VECS[n].evalid);
    end

    // R4: debounce of 3 ticks, two ticks not enough
    dbn_len = 2'd3;
    strobe(12'd900, 12'd80, 12'd70);
    ticks(2);
    read_chk("dbn3 short R4", 0, ONES, 0, 0, 0, 4'h0);
    ticks(3);
    read_chk("dbn3 full R4", 0, 12'd900, 12'd900, 12'd80, 12'd70, 4'hF);

    // R4: debounce length 0 acts as 1
    dbn_len = 2'd0;
    strobe(12'd800, 12'd81, 12'd71);
    ticks(1);
    read_chk("dbn0 R4", 0, 12'd800, 12'd800, 12'd81, 12'd71, 4'hF);

    // R5: blanking of 3 ticks after a mode change
    dbn_len = 2'd1;
    blank_len = 8'd3;
    mode_chg = 1;
    @(negedge clk);
    mode_chg = 0;
    strobe(12'd600, 12'd82, 12'd72);
    ticks(3);
    read_chk("blank on R5", 0, ONES, 0, 0, 0, 4'h0);
    ticks(1);
    read_chk("blank off R5", 0, 12'd600, 12'd600, 12'd82, 12'd72, 4'hF);

    // R7: value qualifying in the read cycle lands in the new window
    strobe(12'd550, 12'd83, 12'd73);
    read_chk("rd+tick old R7", 1, ONES, 0, 0, 0, 4'h0);
    read_chk("rd+tick new R7", 0, 12'd550, 12'd550, 12'd83, 12'd73, 4'hF);

    // R6: back-to-back read sees a cleared window, ready drops after one cycle
    read_chk("b2b R6", 0, ONES, 0, 0, 0, 4'h0);
    @(negedge clk);
    check("ready drop R6", snap_ready, 0);
    check("hold R6", snap_valid, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule